// File: doc/BRIEF.md
# Folded Master-Slave CORDIC Sine/Cosine Unit

The unit takes a signed 2-D vector (x, y) and returns the cosine and sine of its angle. These are the two coefficients a Givens rotation needs to null the second component of a column pair. Two CORDIC sections work side by side:

- A vectoring section drives the residual y of the input toward zero.
- A rotation section turns a unit-length seed vector by the same micro-rotations.

Each vectoring step picks a direction from the sign of its residual y, and that direction also tells the rotation step whether to add or subtract. No angle value is ever formed.

The rotation section starts at 1/K rather than 1, where K is the CORDIC gain. Its final state is therefore already the unit-scaled cosine and sine, and no output multiplier is needed. Vectors with negative x are turned by 180 degrees before the iterations start, so the angle always stays inside the CORDIC convergence range. The seed is negated to match, so the outputs still describe the original vector.

Sixteen micro-rotations are folded onto four combinational stages, and these four stages are reused over four clock cycles. One request is handled at a time. A start pulse is taken only while the unit is idle.

Top module: `sincos_rotator`

## Requirements
- R1: After reset, `valid` is low and `cosOut` and `sinOut` are zero.
- R2: A start taken while idle produces `valid` high exactly 4 clock edges after the accepting edge. The pulse lasts one cycle.
- R3: A start raised while a request is in flight is ignored. It produces no extra `valid` and does not disturb the result in progress.
- R4: For inputs with x >= 0, `cosOut` equals x/|v| and `sinOut` equals y/|v|, each within 12 LSB. Both are signed Q1.14, so 16384 means 1.0.
- R5: For inputs with x < 0, the same R4 relation holds in the second and third quadrants.
- R6: Axis and extreme inputs give correct results: (0, +a) gives (0, 16384), (0, -a) gives (0, -16384), (-32768, 0) gives (-16384, 0), and (-32768, -32768) gives about (-11585, -11585).
- R7: The CORDIC gain is compensated, so the result depends only on direction. A small and a large vector with the same direction give the R4 values within tolerance.
- R8: `cosOut` and `sinOut` hold their last result in every cycle in which `valid` is low.
- R9: A new start can be taken on the cycle in which `valid` is high, which gives a request every 5 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| xIn | input | 16 | Vector x component, signed integer |
| yIn | input | 16 | Vector y component, signed integer |
| valid | output | 1 | One-cycle result strobe |
| cosOut | output | 16 | Cosine of the vector angle, signed Q1.14 |
| sinOut | output | 16 | Sine of the vector angle, signed Q1.14 |

## Verification
The assertions assume that the operands only matter on the cycle a start is taken, and that a zero vector is never presented. For a zero vector the angle is undefined and the rotation section would simply run through every step in one direction. The stimulus never drives (0, 0) and keeps every vector magnitude at 1000 or more, so rounding inside the vectoring section cannot flip a direction decision near zero. The bench drives starts on idle cycles and also during the busy window. The busy-window starts are the ones the control assertions expect to have no effect.

// File: rtl/sincos_pkg.sv
package sincos_pkg;
  parameter int unsigned DATA_W = 16;
  parameter int unsigned STAGES = 4;
  localparam int unsigned PASSES  = DATA_W / STAGES;
  localparam int unsigned PASS_W  = (PASSES > 1) ? $clog2(PASSES) : 1;
  localparam int unsigned SHIFT_W = $clog2(DATA_W);

  // strobes from control to datapath
  typedef struct packed {
    logic              load;   // capture operands, seed the rotation section
    logic              step;   // apply one pass of STAGES micro-rotations
    logic              done;   // last pass: register the result
    logic [PASS_W-1:0] pass;   // which group of shift amounts is in use
  } strobe_t;
endpackage

// File: rtl/sincos_ctrl.sv
module sincos_ctrl
  import sincos_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  output strobe_t strobes
);
  logic              busy;
  logic [PASS_W-1:0] passCnt;
  logic              lastPass;

  assign lastPass = (passCnt == PASS_W'(PASSES - 1));

  always_comb begin
    strobes.load = start && !busy;
    strobes.step = busy;
    strobes.done = busy && lastPass;
    strobes.pass = passCnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      passCnt <= '0;
    end else if (strobes.load) begin
      busy    <= 1'b1;
      passCnt <= '0;
    end else if (busy) begin
      if (lastPass) busy <= 1'b0;
      passCnt <= passCnt + 1'b1;
    end
  end

  // R2: an accepted start begins at pass zero with the unit busy
  p_load_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load |=> busy && passCnt == '0);

  // R3: while busy the passes advance whatever start does
  p_busy_advances_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !lastPass) |=> busy && passCnt == $past(passCnt) + 1'b1);

  // R9: the unit is idle right after its final pass
  p_done_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.done |=> !busy);
endmodule

// File: rtl/sincos_microrot.sv
module sincos_microrot #(
  parameter int unsigned MW = 22,
  parameter int unsigned SW = 20,
  parameter int unsigned SHW = 4
) (
  input  logic signed [MW-1:0]  mxI,
  input  logic signed [MW-1:0]  myI,
  input  logic signed [SW-1:0]  sxI,
  input  logic signed [SW-1:0]  syI,
  input  logic        [SHW-1:0] shift,
  output logic signed [MW-1:0]  mxO,
  output logic signed [MW-1:0]  myO,
  output logic signed [SW-1:0]  sxO,
  output logic signed [SW-1:0]  syO
);
  logic signed [MW-1:0] mxSh, mySh;
  logic signed [SW-1:0] sxSh, sySh;
  logic                 towardNeg;

  assign mxSh = mxI >>> shift;
  assign mySh = myI >>> shift;
  assign sxSh = sxI >>> shift;
  assign sySh = syI >>> shift;
  assign towardNeg = !myI[MW-1];  // residual y >= 0: rotate master clockwise

  always_comb begin
    if (towardNeg) begin
      mxO = mxI + mySh;
      myO = myI - mxSh;
      sxO = sxI - sySh;   // slave goes the other way, accumulating the angle
      syO = syI + sxSh;
    end else begin
      mxO = mxI - mySh;
      myO = myI + mxSh;
      sxO = sxI + sySh;
      syO = syI - sxSh;
    end
  end
endmodule

// File: rtl/sincos_datapath.sv
module sincos_datapath
  import sincos_pkg::*;
#(
  parameter int unsigned EXTRA_FRAC = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  strobe_t                  strobes,
  input  logic signed [DATA_W-1:0] xIn,
  input  logic signed [DATA_W-1:0] yIn,
  output logic                     valid,
  output logic signed [DATA_W-1:0] cosOut,
  output logic signed [DATA_W-1:0] sinOut
);
  localparam int unsigned MW = DATA_W + 2 + EXTRA_FRAC;
  localparam int unsigned SW = DATA_W + EXTRA_FRAC;
  localparam int unsigned FB = DATA_W - 2 + EXTRA_FRAC;
  localparam logic signed [SW-1:0] SEED =
    SW'($rtoi(0.6072529350088813 * (2.0 ** FB) + 0.5));
  localparam logic signed [SW-1:0] HALF = SW'(1) <<< (EXTRA_FRAC - 1);

  logic signed [MW-1:0] mx, my, xExt, yExt;
  logic signed [SW-1:0] sx, sy;
  logic                 negX;

  logic signed [MW-1:0] cMx [STAGES+1];
  logic signed [MW-1:0] cMy [STAGES+1];
  logic signed [SW-1:0] cSx [STAGES+1];
  logic signed [SW-1:0] cSy [STAGES+1];
  logic signed [SW-1:0] cosRnd, sinRnd;

  assign xExt = {{2{xIn[DATA_W-1]}}, xIn, {EXTRA_FRAC{1'b0}}};
  assign yExt = {{2{yIn[DATA_W-1]}}, yIn, {EXTRA_FRAC{1'b0}}};
  assign negX = xIn[DATA_W-1];

  assign cMx[0] = mx;
  assign cMy[0] = my;
  assign cSx[0] = sx;
  assign cSy[0] = sy;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [SHIFT_W-1:0] shAmt;
    assign shAmt = SHIFT_W'(strobes.pass * STAGES + k);
    sincos_microrot #(.MW(MW), .SW(SW), .SHW(SHIFT_W)) u_rot (
      .mxI(cMx[k]), .myI(cMy[k]), .sxI(cSx[k]), .syI(cSy[k]),
      .shift(shAmt),
      .mxO(cMx[k+1]), .myO(cMy[k+1]), .sxO(cSx[k+1]), .syO(cSy[k+1])
    );
  end

  assign cosRnd = cSx[STAGES] + HALF;
  assign sinRnd = cSy[STAGES] + HALF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mx <= '0; my <= '0; sx <= '0; sy <= '0;
    end else if (strobes.load) begin
      // negative x: turn the vector half a circle and negate the seed to match
      mx <= negX ? -xExt : xExt;
      my <= negX ? -yExt : yExt;
      sx <= negX ? -SEED : SEED;
      sy <= '0;
    end else if (strobes.step) begin
      mx <= cMx[STAGES];
      my <= cMy[STAGES];
      sx <= cSx[STAGES];
      sy <= cSy[STAGES];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      cosOut <= '0;
      sinOut <= '0;
    end else begin
      valid <= strobes.done;
      if (strobes.done) begin
        cosOut <= cosRnd[EXTRA_FRAC +: DATA_W];
        sinOut <= sinRnd[EXTRA_FRAC +: DATA_W];
      end
    end
  end

  // R5: after pre-rotation the vectoring x never goes negative
  p_master_x_nonneg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.step |-> !mx[MW-1]);

  // R8: results hold between completions
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.done |=> $stable(cosOut) && $stable(sinOut));

  // R2: the result strobe is a single-cycle pulse
  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
endmodule

// File: rtl/sincos_rotator.sv
module sincos_rotator
  import sincos_pkg::*;
#(
  parameter int unsigned EXTRA_FRAC = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic signed [DATA_W-1:0] xIn,
  input  logic signed [DATA_W-1:0] yIn,
  output logic                     valid,
  output logic signed [DATA_W-1:0] cosOut,
  output logic signed [DATA_W-1:0] sinOut
);
  strobe_t strobes;

  sincos_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .strobes(strobes)
  );

  sincos_datapath #(.EXTRA_FRAC(EXTRA_FRAC)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .xIn(xIn), .yIn(yIn),
    .valid(valid), .cosOut(cosOut), .sinOut(sinOut)
  );
endmodule

// File: tb/test_sincos_rotator.sv
module test_sincos_rotator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [15:0] xIn = '0, yIn = '0;
  logic valid;
  logic signed [15:0] cosOut, sinOut;

  int checks = 0, errors = 0, cyc = 0, stabFails = 0;
  bit monOn = 0, haveLast = 0, prevValid = 0, finished = 0;
  int lastCos, lastSin;
  int qx[$], qy[$], qc[$];
  string qt[$];
  localparam int TOL = 12;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sincos_rotator i_sincos_rotator (
    .clk(clk), .rst_n(rst_n), .start(start), .xIn(xIn), .yIn(yIn),
    .valid(valid), .cosOut(cosOut), .sinOut(sinOut)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic drive(input int x, input int y, input bit expectAccept, input string tag);
    @(negedge clk);
    start = 1'b1;
    xIn = 16'(x);
    yIn = 16'(y);
    if (expectAccept) begin
      qx.push_back(x); qy.push_back(y); qc.push_back(cyc + 5); qt.push_back(tag);
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  // issue a request, then return on the cycle before valid so the next one is back-to-back (R9)
  task automatic send(input int x, input int y, input string tag);
    drive(x, y, 1'b1, tag);
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (monOn) begin
      if (valid) begin
        if (prevValid) check(0, "R2 pulse width", 1, 0);
        if (qx.size() == 0) begin
          check(0, "R3 unexpected valid", 1, 0);
        end else begin
          int x, y, c, ec, es;
          string tag;
          real mag;
          x = qx.pop_front(); y = qy.pop_front(); c = qc.pop_front(); tag = qt.pop_front();
          mag = $sqrt(real'(x) * real'(x) + real'(y) * real'(y));
          ec = int'(real'(x) / mag * 16384.0);
          es = int'(real'(y) / mag * 16384.0);
          check(cyc == c, "R2 latency cycle", cyc, c);
          check((int'(cosOut) - ec <= TOL) && (ec - int'(cosOut) <= TOL),
                {tag, " cos"}, int'(cosOut), ec);
          check((int'(sinOut) - es <= TOL) && (es - int'(sinOut) <= TOL),
                {tag, " sin"}, int'(sinOut), es);
        end
        lastCos = cosOut; lastSin = sinOut; haveLast = 1;
      end else if (haveLast && (int'(cosOut) != lastCos || int'(sinOut) != lastSin)) begin
        stabFails++;
      end
      prevValid = valid;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid == 1'b0, "R1 valid after reset", valid, 0);
    check(cosOut == 0 && sinOut == 0, "R1 outputs after reset", cosOut, 0);
    monOn = 1;

    send(12000, 5000, "R4 q1a");
    send(3000, 20000, "R4 q1b");
    send(20000, -7000, "R4 q4");
    send(-15000, 9000, "R5 q2");
    send(-8000, -22000, "R5 q3");
    send(0, 18000, "R6 +y axis");
    send(0, -32768, "R6 -y axis");
    send(-32768, 0, "R6 -x axis");
    send(-32768, -32768, "R6 corner");
    send(1500, 1500, "R7 small diag");
    send(24000, 24000, "R7 large diag");
    send(2000, -1000, "R7 small");
    send(32000, -16000, "R7 large");

    // R3: starts during the busy window must be ignored
    drive(10000, 10000, 1'b1, "R3 first");
    drive(-20000, 3000, 1'b0, "R3 ignored");
    drive(5000, -30000, 1'b0, "R3 ignored");
    repeat (8) @(negedge clk);
    send(7000, 1000, "R9 after idle");
    send(-1200, 900, "R9 back-to-back");

    repeat (10) @(negedge clk);
    check(qx.size() == 0, "R2 all results returned", qx.size(), 0);
    check(stabFails == 0, "R8 outputs held between results", stabFails, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule